// File: doc/BRIEF.md
# Interrupt Vector and DMA Request Controller

This block collects the event flags of a byte-oriented serial bus master, masks them into a single interrupt line and turns the two data-ready flags into DMA request lines. The transfer engine raises flags with one-cycle set pulses. Software reads and acknowledges them through a small 16-bit register port with a word address and read and write strobes. Read data is registered and appears in the cycle after the read strobe.

Two revisions are covered, chosen by the parameter `NEW_REV`. In the older revision (`NEW_REV=0`), software acknowledges a flag by reading a vector register. That read returns the one-based index of the lowest pending enabled flag and clears that flag. The status register cannot be written. In the newer revision (`NEW_REV=1`), software clears flags by writing ones to the status register, and the vector register reads zero. The newer revision also has a self-test write that raises the low six flags at once.

Turning on a DMA channel quietly drops the matching data-ready bit from the interrupt mask, so the same event is not serviced twice. The interrupt and DMA request outputs are registered. They change on the same clock edge as the state they are computed from.

Top module: `ivec_ctrl`

Register word addresses: 0 enable mask, 1 status, 2 vector, 3 DMA enable, 4 self-test. Any other address reads zero and ignores writes.

## Requirements
- R1: After synchronous active-low reset, the status, enable mask and DMA enables read zero, and `irq_o`, `rx_dreq_o` and `tx_dreq_o` are low.
- R2: `irq_o` is high exactly when some status bit and the enable-mask bit in the same position are both one. It reflects the state after each clock edge.
- R3: `rx_dreq_o` equals status bit 3 (receive ready) ANDed with DMA-enable bit 15. `tx_dreq_o` equals status bit 4 (transmit ready) ANDed with DMA-enable bit 7.
- R4: A write to the enable mask (address 0) keeps bits 4..0 in the older revision and bits 5..0 in the newer revision. Other written bits read back as zero.
- R5: A write to the DMA-enable register (address 3) keeps only bits 15 and 7. Writing bit 15 as one clears mask bit 3, and writing bit 7 as one clears mask bit 4.
- R6: A status read (address 1) returns the stored flags with the live `bus_busy` input in bit 12. Stored bit 12 is never set, even by a set pulse. Read data appears on `rdata` one cycle after `rd_en`.
- R7: In the older revision, a vector read (address 2) returns one plus the position of the lowest bit set in both status and mask, or zero if there is none, and clears that status bit. In the newer revision, a vector read returns zero and changes nothing.
- R8: In the newer revision, a status write clears each status bit that is written as one within mask 0x0027. In the older revision, a status write has no effect.
- R9: In the newer revision, a self-test write (address 4) with bit 11 set forces status bits 5..0 to one. In the older revision, it has no effect.
- R10: A set pulse on a status bit in the same cycle as a software clear of that bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, valid the cycle after `rd_en` |
| set_pulse | input | 16 | One-cycle flag set pulses from the transfer engine |
| bus_busy | input | 1 | Live bus-busy indication |
| irq_o | output | 1 | Interrupt request |
| rx_dreq_o | output | 1 | Receive DMA request |
| tx_dreq_o | output | 1 | Transmit DMA request |

## Verification
Some properties are checked by assertions on every cycle:
- a set pulse always wins over a simultaneous clear;
- a DMA-enable write removes the matching mask bit;
- an older-revision vector acknowledge removes exactly one pending flag;
- the older-revision status register ignores writes;
- the busy bit in read data tracks the input.

Other behaviour only the bench scenarios can show. This covers the exact vector codes in priority order, the read-back widths of the mask in each revision, the self-test forcing, and how the interrupt and request lines move as flags and enables change.

// File: rtl/ivec_pkg.sv
// Package ivec_pkg
// Shared register addresses, bit positions and masks for the interrupt
// vector and DMA request controller. Assumes a 16-bit register port.
package ivec_pkg;
    localparam int REG_W     = 16;
    localparam int MASK_MAX  = 6;
    localparam int RX_BIT    = 3;
    localparam int TX_BIT    = 4;
    localparam int BUSY_BIT  = 12;
    localparam int RXDMA_BIT = 15;
    localparam int TXDMA_BIT = 7;
    localparam int FORCE_BIT = 11;

    localparam logic [REG_W-1:0] W1C_MASK   = 16'h0027;
    localparam logic [REG_W-1:0] FORCE_MASK = 16'h003F;
    localparam logic [REG_W-1:0] STAT_KEEP  = ~(16'h0001 << BUSY_BIT);

    typedef enum logic [2:0] {
        A_MASK = 3'd0,
        A_STAT = 3'd1,
        A_VEC  = 3'd2,
        A_DMA  = 3'd3,
        A_TEST = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/ivec_prio.sv
// Module ivec_prio
// Finds the lowest set bit of a pending vector. It returns that bit's
// position plus one (zero if no bit is set) and a one-hot copy of it.
// The logic is purely combinational; lower positions have the higher priority.
module ivec_prio #(
    parameter int W = 6,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  pend,
    output logic [CW-1:0] code,
    output logic [W-1:0]  onehot
);
    // Scan from the top down so the lowest set bit is the last one assigned.
    always_comb begin
        code   = '0;
        onehot = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (pend[i]) begin
                code   = CW'(i + 1);
                onehot = W'(1) << i;
            end
        end
    end
endmodule

// File: rtl/ivec_status.sv
// Module ivec_status
// Holds the status flags. Each cycle it applies software clears first,
// then the forced bits, then the engine set pulses, so a set always wins
// over a clear. The busy bit position is never stored. Also exposes the
// next-state value so the registered outputs can follow the same edge.
module ivec_status
    import ivec_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_pulse,
    input  logic [W-1:0] sw_clr,
    input  logic [W-1:0] sw_force,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] stat_d
);
    // Next-state: clear, then force, then set (set has the highest priority).
    always_comb begin
        stat_d = (((stat_q & ~sw_clr) | sw_force) | set_pulse) & STAT_KEEP;
    end

    // Flag register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // R10: a bit pulsed by the engine is set after the edge, even if software cleared it.
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_pulse & STAT_KEEP)) |=>
            ((stat_q & $past(set_pulse & STAT_KEEP)) == $past(set_pulse & STAT_KEEP)));

    // R6: the busy position is never stored.
    p_no_busy_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !stat_q[BUSY_BIT]);
endmodule

// File: rtl/ivec_cfg.sv
// Module ivec_cfg
// Holds the interrupt enable mask and the two DMA enables. Writing a DMA
// enable as one drops the matching data-ready mask bit. The mask width
// depends on the revision. Only one of the two writes happens per cycle.
module ivec_cfg
    import ivec_pkg::*;
#(
    parameter bit NEW_REV = 1'b1,
    localparam logic [MASK_MAX-1:0] MASK_KEEP = NEW_REV ? 6'h3F : 6'h1F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_mask,
    input  logic                wr_dma,
    input  logic [REG_W-1:0]    wdata,
    output logic [MASK_MAX-1:0] mask_q,
    output logic [MASK_MAX-1:0] mask_d,
    output logic                rx_en_q,
    output logic                tx_en_q,
    output logic                rx_en_d,
    output logic                tx_en_d
);
    // Next-state for the mask and the DMA enables.
    always_comb begin
        mask_d  = mask_q;
        rx_en_d = rx_en_q;
        tx_en_d = tx_en_q;
        if (wr_mask) begin
            mask_d = wdata[MASK_MAX-1:0] & MASK_KEEP;
        end else if (wr_dma) begin
            rx_en_d = wdata[RXDMA_BIT];
            tx_en_d = wdata[TXDMA_BIT];
            if (wdata[RXDMA_BIT]) mask_d[RX_BIT] = 1'b0;
            if (wdata[TXDMA_BIT]) mask_d[TX_BIT] = 1'b0;
        end
    end

    // Configuration registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            rx_en_q <= 1'b0;
            tx_en_q <= 1'b0;
        end else begin
            mask_q  <= mask_d;
            rx_en_q <= rx_en_d;
            tx_en_q <= tx_en_d;
        end
    end

    // R5: turning on receive DMA removes the receive-ready interrupt enable.
    p_rx_dma_unmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dma && !wr_mask && wdata[RXDMA_BIT]) |=> (!mask_q[RX_BIT] && rx_en_q));

    // R5: turning on transmit DMA removes the transmit-ready interrupt enable.
    p_tx_dma_unmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dma && !wr_mask && wdata[TXDMA_BIT]) |=> (!mask_q[TX_BIT] && tx_en_q));
endmodule

// File: rtl/ivec_ctrl.sv
// Module ivec_ctrl
// Top level of the interrupt vector and DMA request controller.
// It decodes register accesses, routes the revision-dependent
// acknowledge paths into the status flags, registers the read data,
// and registers the interrupt and DMA request outputs from the
// next-state values. Assumes one access per address per cycle.
module ivec_ctrl
    import ivec_pkg::*;
#(
    parameter bit NEW_REV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [REG_W-1:0]  set_pulse,
    input  logic              bus_busy,
    output logic              irq_o,
    output logic              rx_dreq_o,
    output logic              tx_dreq_o
);
    localparam int CW = $clog2(MASK_MAX + 1);

    logic                wr_mask, wr_stat, wr_dma, wr_test, rd_vec;
    logic [REG_W-1:0]    stat_q, stat_d, sw_clr, sw_force;
    logic [MASK_MAX-1:0] mask_q, mask_d, pend, ack_onehot;
    logic                rx_en_q, tx_en_q, rx_en_d, tx_en_d;
    logic [CW-1:0]       vec_code;
    logic [REG_W-1:0]    rd_mux;

    // Decode the register strobes.
    always_comb begin
        wr_mask = wr_en && (addr == A_MASK);
        wr_stat = wr_en && (addr == A_STAT);
        wr_dma  = wr_en && (addr == A_DMA);
        wr_test = wr_en && (addr == A_TEST);
        rd_vec  = rd_en && (addr == A_VEC);
    end

    assign pend = stat_q[MASK_MAX-1:0] & mask_q;

    ivec_prio #(.W(MASK_MAX)) u_prio (
        .pend   (pend),
        .code   (vec_code),
        .onehot (ack_onehot)
    );

    // Choose the software clear and force sources for the selected revision.
    generate
        if (NEW_REV) begin : g_new
            always_comb begin
                sw_clr   = wr_stat ? (wdata & W1C_MASK) : '0;
                sw_force = (wr_test && wdata[FORCE_BIT]) ? FORCE_MASK : '0;
            end
        end else begin : g_old
            always_comb begin
                sw_clr   = rd_vec ? REG_W'(ack_onehot) : '0;
                sw_force = '0;
            end
        end
    endgenerate

    ivec_status #(.W(REG_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (set_pulse),
        .sw_clr    (sw_clr),
        .sw_force  (sw_force),
        .stat_q    (stat_q),
        .stat_d    (stat_d)
    );

    ivec_cfg #(.NEW_REV(NEW_REV)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_dma  (wr_dma),
        .wdata   (wdata),
        .mask_q  (mask_q),
        .mask_d  (mask_d),
        .rx_en_q (rx_en_q),
        .tx_en_q (tx_en_q),
        .rx_en_d (rx_en_d),
        .tx_en_d (tx_en_d)
    );

    // Read data multiplexer over the register map.
    always_comb begin
        rd_mux = '0;
        case (addr)
            A_MASK: rd_mux = REG_W'(mask_q);
            A_STAT: begin
                rd_mux           = stat_q;
                rd_mux[BUSY_BIT] = bus_busy;
            end
            A_VEC:  rd_mux = NEW_REV ? '0 : REG_W'(vec_code);
            A_DMA:  begin
                rd_mux[RXDMA_BIT] = rx_en_q;
                rd_mux[TXDMA_BIT] = tx_en_q;
            end
            default: rd_mux = '0;
        endcase
    end

    // Registered read data; it holds its value between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // Registered request outputs, taken from the next state so they change on the same edge as it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            rx_dreq_o <= 1'b0;
            tx_dreq_o <= 1'b0;
        end else begin
            irq_o     <= |(stat_d[MASK_MAX-1:0] & mask_d);
            rx_dreq_o <= stat_d[RX_BIT] & rx_en_d;
            tx_dreq_o <= stat_d[TX_BIT] & tx_en_d;
        end
    end

    // R2: the interrupt line agrees with the stored flags and mask.
    p_irq_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_o == (|(stat_q[MASK_MAX-1:0] & mask_q))));

    // R3: a DMA request line is never high while its channel is disabled.
    p_dreq_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dreq_o |-> rx_en_q) and (tx_dreq_o |-> tx_en_q));

    // R6: bit 12 of status read data is the busy input sampled at the read.
    p_busy_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_STAT) |=> (rdata[BUSY_BIT] == $past(bus_busy)));

    // R7: an older-revision vector acknowledge removes exactly one pending flag.
    p_vec_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!NEW_REV && rd_vec && (|pend) && !wr_en && (set_pulse == '0)) |=>
            ($countones(stat_q) == $countones($past(stat_q)) - 1));

    // R8: in the older revision a status write leaves the flags unchanged.
    p_old_stat_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!NEW_REV && wr_stat && !rd_en && (set_pulse == '0)) |=> $stable(stat_q));
endmodule

// File: tb/sim_ivec_ctrl.sv
// Scoreboard bench: driver tasks push expected read data into a queue,
// and a monitor pops and compares when read data becomes valid.
// u0 uses the newer revision; u1 uses the older revision.
module sim_ivec_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr0 = 0, wr1 = 0, rd0 = 0, rd1 = 0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0, sp0 = '0, sp1 = '0;
    logic        busy = 1'b0;
    logic [15:0] rdata0, rdata1;
    logic        irq0, rx0, tx0, irq1, rx1, tx1;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int          inst;
        logic [15:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sbq[$];

    always #10 clk = ~clk;

    ivec_ctrl #(.NEW_REV(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr0), .rd_en(rd0), .addr(addr),
        .wdata(wdata), .rdata(rdata0), .set_pulse(sp0), .bus_busy(busy),
        .irq_o(irq0), .rx_dreq_o(rx0), .tx_dreq_o(tx0));

    ivec_ctrl #(.NEW_REV(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr1), .rd_en(rd1), .addr(addr),
        .wdata(wdata), .rdata(rdata1), .set_pulse(sp1), .bus_busy(busy),
        .irq_o(irq1), .rx_dreq_o(rx1), .tx_dreq_o(tx1));

    // Monitor: read data is valid in the cycle after a read strobe.
    logic pend0 = 0, pend1 = 0;
    always @(posedge clk) begin
        pend0 <= rd0;
        pend1 <= rd1;
    end
    always @(negedge clk) begin
        if (pend0 || pend1) begin
            sb_item_t it;
            logic [15:0] act;
            it  = sbq.pop_front();
            act = (it.inst == 0) ? rdata0 : rdata1;
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s u%0d rdata act=%h exp=%h", it.tag, it.inst, act, it.exp);
            end
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic clr_drv();
        wr0 = 0; wr1 = 0; rd0 = 0; rd1 = 0; sp0 = '0; sp1 = '0;
    endtask

    task automatic wr(int inst, logic [2:0] a, logic [15:0] d, logic [15:0] sp);
        addr = a; wdata = d;
        if (inst == 0) begin wr0 = 1; sp0 = sp; end
        else           begin wr1 = 1; sp1 = sp; end
        @(negedge clk);
        clr_drv();
    endtask

    task automatic rd(int inst, logic [2:0] a, logic [15:0] exp, string tag, logic [15:0] sp);
        sb_item_t it;
        it.inst = inst; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        addr = a;
        if (inst == 0) begin rd0 = 1; sp0 = sp; end
        else           begin rd1 = 1; sp1 = sp; end
        @(negedge clk);
        clr_drv();
    endtask

    task automatic pulse(int inst, logic [15:0] sp);
        if (inst == 0) sp0 = sp; else sp1 = sp;
        @(negedge clk);
        clr_drv();
    endtask

    task automatic finish_run();
        @(negedge clk);
        @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 irq0", irq0, 0); chk("R1 rx0", rx0, 0); chk("R1 tx0", tx0, 0);
        chk("R1 irq1", irq1, 0);
        rd(0, 3'd1, 16'h0000, "R1 status", '0);
        rd(0, 3'd0, 16'h0000, "R1 mask", '0);
        rd(0, 3'd3, 16'h0000, "R1 dma", '0);

        // ---- newer revision (u0) ----
        wr(0, 3'd0, 16'hFFFF, '0);
        rd(0, 3'd0, 16'h003F, "R4 new mask width", '0);
        pulse(0, 16'h0008);
        chk("R2 irq on rx ready", irq0, 1);
        chk("R3 rx dreq off without dma", rx0, 0);
        wr(0, 3'd3, 16'hFFFF, '0);
        rd(0, 3'd3, 16'h8080, "R5 dma keep bits", '0);
        rd(0, 3'd0, 16'h0027, "R5 mask bits 3,4 dropped", '0);
        chk("R2 irq low after unmask", irq0, 0);
        chk("R3 rx dreq follows", rx0, 1);
        pulse(0, 16'h0010);
        chk("R3 tx dreq follows", tx0, 1);
        busy = 1'b1;
        rd(0, 3'd1, 16'h1018, "R6 busy in bit 12", '0);
        busy = 1'b0;
        wr(0, 3'd1, 16'hFFFF, '0);
        rd(0, 3'd1, 16'h0018, "R8 w1c limited to 0x27", '0);
        pulse(0, 16'h0003);
        chk("R2 irq from bits 0,1", irq0, 1);
        wr(0, 3'd1, 16'h0001, '0);
        rd(0, 3'd1, 16'h001A, "R8 single bit clear", '0);
        wr(0, 3'd1, 16'h0002, 16'h0002);
        rd(0, 3'd1, 16'h001A, "R10 set beats clear", '0);
        wr(0, 3'd4, 16'h0800, '0);
        rd(0, 3'd1, 16'h003F, "R9 self-test force", '0);
        rd(0, 3'd2, 16'h0000, "R7 new vector reads zero", '0);
        rd(0, 3'd1, 16'h003F, "R7 new vector no clear", '0);
        pulse(0, 16'h1000);
        rd(0, 3'd1, 16'h003F, "R6 bit 12 not stored", '0);
        wr(0, 3'd3, 16'h0000, '0);
        chk("R3 rx dreq drops with enable", rx0, 0);
        chk("R3 tx dreq drops with enable", tx0, 0);

        // ---- older revision (u1) ----
        wr(1, 3'd0, 16'hFFFF, '0);
        rd(1, 3'd0, 16'h001F, "R4 old mask width", '0);
        wr(1, 3'd0, 16'h001C, '0);
        pulse(1, 16'h0015);
        chk("R2 old irq", irq1, 1);
        rd(1, 3'd2, 16'h0003, "R7 vector lowest (bit2)", '0);
        rd(1, 3'd2, 16'h0005, "R7 vector next (bit4)", '0);
        rd(1, 3'd2, 16'h0000, "R7 vector none enabled", '0);
        rd(1, 3'd1, 16'h0001, "R7 acked bits cleared", '0);
        chk("R2 old irq cleared", irq1, 0);
        wr(1, 3'd1, 16'hFFFF, '0);
        rd(1, 3'd1, 16'h0001, "R8 old status read-only", '0);
        wr(1, 3'd4, 16'h0800, '0);
        rd(1, 3'd1, 16'h0001, "R9 old self-test ignored", '0);
        pulse(1, 16'h0004);
        rd(1, 3'd2, 16'h0003, "R10 vector with set pulse", 16'h0004);
        rd(1, 3'd1, 16'h0005, "R10 pulsed bit kept", '0);
        wr(1, 3'd3, 16'h0080, '0);
        rd(1, 3'd0, 16'h000C, "R5 old tx dma unmask", '0);
        rd(1, 3'd3, 16'h0080, "R5 old dma readback", '0);
        chk("R3 old tx dreq low (bit4 clear)", tx1, 0);

        finish_run();
    end
endmodule